// File: doc/BRIEF.md
# Timer Output-Compare Channel with Forced Compare

This block is a single output-compare channel that sits beside a timer/counter. On every clock it checks whether the counter has advanced onto the programmed compare value. When that happens, it drives a waveform pin according to a 2-bit action code. It also raises a one-cycle interrupt pulse. In clear-on-match operation it also asks the counter to restart. The counter, its prescaler and any PWM waveform shaping live elsewhere. This channel only receives a non-PWM/PWM indication through the waveform-mode input.

Software can also pulse a forced-compare strobe. In the non-PWM modes this strobe moves the pin exactly as a real match would, using whatever action code is present in that cycle. A forced compare is silent in every other respect: it raises no interrupt and never requests a counter restart. In the PWM modes the strobe is ignored. When a real match and a force land in the same cycle, the pin action is applied once. The strobe is write-only and has no read-back path.

Top module: `oc_channel`

## Requirements
- R1: While `rst_n` is low, and after its release until the first event, `wave_out`, `cmp_irq` and `clr_req` are all 0.
- R2: A real match in waveform mode 0 (free-running) or mode 1 (clear-on-match) updates `wave_out` on the next clock according to `out_mode`: 0 = hold, 1 = invert, 2 = drive 0, 3 = drive 1.
- R3: A real match pulses `cmp_irq` high for exactly one cycle, one clock later, in every waveform mode.
- R4: A real match in waveform mode 1 pulses `clr_req` for exactly one cycle, one clock later. In modes 0, 2 and 3, `clr_req` stays 0.
- R5: A `force_stb` pulse in waveform mode 0 or 1 updates `wave_out` on the next clock with the same `out_mode` action as a real match.
- R6: A `force_stb` pulse without a real match leaves `cmp_irq` and `clr_req` at 0 in every waveform mode.
- R7: In waveform modes 2 and 3 (PWM, bit 1 of `wave_mode` set), neither a force nor a match changes `wave_out`.
- R8: A real match and a `force_stb` in the same cycle apply the `out_mode` action once. In invert mode the pin flips a single time.
- R9: A real match requires `cnt_tick` = 1 and `cnt_val` equal to `cmp_val`. Equal values with `cnt_tick` = 0 produce no pin change, no interrupt and no clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_tick | input | 1 | Counter advanced this cycle |
| cmp_val | input | CNT_W | Compare register |
| wave_mode | input | 2 | 0 free-running, 1 clear-on-match, 2/3 PWM |
| out_mode | input | 2 | Pin action on compare: 0 hold, 1 invert, 2 low, 3 high |
| force_stb | input | 1 | One-cycle forced-compare strobe |
| wave_out | output | 1 | Waveform pin |
| cmp_irq | output | 1 | One-cycle compare interrupt pulse |
| clr_req | output | 1 | One-cycle counter-clear request |

## Verification
A wrong pin register shows on `wave_out` one clock after the event that should have moved it. A wrongly merged event path shows in one of two ways: an interrupt or clear pulse after a force-only cycle, or a double flip when a match and a force coincide. Both appear in that same next cycle. The sweep first presets the pin to each level. It then covers every waveform mode, action code and event kind, and checks the pulse outputs both in the cycle after the event and in the cycle after that, so a pulse that sticks is seen within two clocks.

// File: rtl/oc_pkg.sv
// Shared types and helpers for the output-compare channel.
// Assumes 2-bit waveform-mode and action codes as listed in the brief.
package oc_pkg;

    typedef enum logic [1:0] {
        WM_FREE   = 2'd0,
        WM_CLRMAT = 2'd1,
        WM_PWM_A  = 2'd2,
        WM_PWM_B  = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_INVERT = 2'd1,
        OM_LOW    = 2'd2,
        OM_HIGH   = 2'd3
    } out_mode_e;

    // PWM modes are the ones with the upper code bit set.
    function automatic logic is_pwm(input wave_mode_e m);
        return m[1];
    endfunction

    // Next pin level for a given action code and present level.
    function automatic logic pin_action(input out_mode_e om, input logic cur);
        case (om)
            OM_HOLD:   return cur;
            OM_INVERT: return ~cur;
            OM_LOW:    return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/oc_match_detect.sv
// Real compare-match detector.
// Assumes cnt_tick marks a cycle in which the counter holds a freshly
// reached value; equality without a tick is not a match.
module oc_match_detect #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_tick,
    output logic             match_hit
);
    logic [CNT_W-1:0] bit_eq;

    // Per-bit equality, reduced below.
    for (genvar i = 0; i < CNT_W; i++) begin : g_eq
        assign bit_eq[i] = ~(cnt_val[i] ^ cmp_val[i]);
    end

    // Match only when counting and every bit agrees.
    always_comb begin
        match_hit = cnt_tick & (&bit_eq);
    end
endmodule

// File: rtl/oc_event_ctrl.sv
// Merges real and forced compares into one pin event and produces the
// interrupt and counter-clear pulses from real matches only.
// Assumes force_stb is a single-cycle strobe.
module oc_event_ctrl
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_hit,
    input  logic       force_stb,
    input  logic [1:0] wave_mode,
    output logic       pin_event,
    output logic       cmp_irq,
    output logic       clr_req
);
    wave_mode_e wm;

    // Decode mode and form the single merged pin event.
    always_comb begin
        wm        = wave_mode_e'(wave_mode);
        pin_event = ~is_pwm(wm) & (match_hit | force_stb);
    end

    // Registered pulses: interrupt on any real match, clear only in clear-on-match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_irq <= 1'b0;
            clr_req <= 1'b0;
        end else begin
            cmp_irq <= match_hit;
            clr_req <= match_hit & (wm == WM_CLRMAT);
        end
    end
endmodule

// File: rtl/oc_wave_gen.sv
// Waveform pin register applying the compare action once per event.
// Assumes pin_event is already gated for PWM modes.
module oc_wave_gen
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_event,
    input  logic [1:0] out_mode,
    output logic       wave_out
);
    logic pin_next;

    // Next pin level from the action code present in this cycle.
    always_comb begin
        pin_next = pin_event ? pin_action(out_mode_e'(out_mode), wave_out) : wave_out;
    end

    // Pin state register, low out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_out <= 1'b0;
        else        wave_out <= pin_next;
    end
endmodule

// File: rtl/oc_channel.sv
// One output-compare channel: match detection, event merging and pin drive.
// Assumes the counter and prescaler are external and supply cnt_tick.
module oc_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic             force_stb,
    output logic             wave_out,
    output logic             cmp_irq,
    output logic             clr_req
);
    logic match_hit;
    logic pin_event;

    oc_match_detect #(.CNT_W(CNT_W)) u_match (
        .cnt_val   (cnt_val),
        .cmp_val   (cmp_val),
        .cnt_tick  (cnt_tick),
        .match_hit (match_hit)
    );

    oc_event_ctrl u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_hit (match_hit),
        .force_stb (force_stb),
        .wave_mode (wave_mode),
        .pin_event (pin_event),
        .cmp_irq   (cmp_irq),
        .clr_req   (clr_req)
    );

    oc_wave_gen u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_event (pin_event),
        .out_mode  (out_mode),
        .wave_out  (wave_out)
    );
endmodule

// File: rtl/oc_channel_chk.sv
// Property checker for oc_channel, attached by bind below.
// Recomputes the match condition from the ports only.
module oc_channel_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] cmp_val,
    input logic [1:0]       wave_mode,
    input logic [1:0]       out_mode,
    input logic             force_stb,
    input logic             wave_out,
    input logic             cmp_irq,
    input logic             clr_req
);
    logic real_m;
    assign real_m = cnt_tick && (cnt_val == cmp_val);

    AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        real_m |=> cmp_irq); // R3
    AST_FORCE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !real_m |=> !cmp_irq); // R6
    AST_CLR_IN_CTC: assert property (@(posedge clk) disable iff (!rst_n)
        (real_m && wave_mode == 2'd1) |=> clr_req); // R4
    AST_NO_CLR_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(real_m && wave_mode == 2'd1) |=> !clr_req); // R4
    AST_PWM_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wave_mode[1] |=> $stable(wave_out)); // R7
    AST_IDLE_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!real_m && !force_stb) |=> $stable(wave_out)); // R9
    AST_INVERT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_mode[1] && out_mode == 2'd1 && (real_m || force_stb))
        |=> wave_out != $past(wave_out)); // R8
    AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_mode[1] && out_mode == 2'd2 && (real_m || force_stb)) |=> !wave_out); // R5
    AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_mode[1] && out_mode == 2'd3 && (real_m || force_stb)) |=> wave_out); // R2
    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |=> $stable(wave_out)); // R2
endmodule

bind oc_channel oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .cmp_val(cmp_val), .wave_mode(wave_mode), .out_mode(out_mode),
    .force_stb(force_stb), .wave_out(wave_out), .cmp_irq(cmp_irq),
    .clr_req(clr_req)
);

// File: tb/oc_channel_test.sv
module oc_channel_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic [W-1:0] cmp_val = '0;
    logic         cnt_tick = 1'b0;
    logic         force_stb = 1'b0;
    logic [1:0]   wave_mode = 2'd0;
    logic [1:0]   out_mode = 2'd0;
    logic         wave_out, cmp_irq, clr_req;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic exp_pin = 1'b0;

    always #2 clk = ~clk;

    oc_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .cmp_val(cmp_val), .wave_mode(wave_mode), .out_mode(out_mode),
        .force_stb(force_stb), .wave_out(wave_out), .cmp_irq(cmp_irq),
        .clr_req(clr_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic act_of(input logic [1:0] om, input logic cur);
        case (om)
            2'd0:    return cur;
            2'd1:    return ~cur;
            2'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Drive the pin to a known level with a forced compare in mode 0.
    task automatic preset(input logic p);
        wave_mode = 2'd0;
        out_mode  = p ? 2'd3 : 2'd2;
        cnt_tick  = 1'b0;
        force_stb = 1'b1;
        step();
        force_stb = 1'b0;
        exp_pin   = p;
        chk("R5 preset pin", wave_out, exp_pin);
        chk("R6 preset irq", cmp_irq, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 pin in reset", wave_out, 1'b0);
        chk("R1 irq in reset", cmp_irq, 1'b0);
        chk("R1 clr in reset", clr_req, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 pin after release", wave_out, 1'b0);
        chk("R1 irq after release", cmp_irq, 1'b0);
        chk("R1 clr after release", clr_req, 1'b0);

        // kind: 0 match, 1 force only, 2 match+force, 3 equal without tick
        for (int wm = 0; wm < 4; wm++) begin
            for (int om = 0; om < 4; om++) begin
                for (int kind = 0; kind < 4; kind++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic  m, f, pwm, ev;
                        string tp, ti, tc;
                        preset(p[0]);
                        m   = (kind == 0) || (kind == 2);
                        f   = (kind == 1) || (kind == 2);
                        pwm = (wm >= 2);
                        ev  = !pwm && (m || f);
                        wave_mode = wm[1:0];
                        out_mode  = om[1:0];
                        cmp_val   = W'(wm * 53 + om * 17 + kind * 5 + p * 101);
                        cnt_val   = (kind == 1) ? W'(cmp_val + 1) : cmp_val;
                        cnt_tick  = (kind != 3);
                        force_stb = f;
                        if (ev) exp_pin = act_of(om[1:0], exp_pin);
                        tp = pwm ? "R7 pin" : (kind == 2) ? "R8 pin" :
                             (kind == 1) ? "R5 pin" : (kind == 0) ? "R2 pin" : "R9 pin";
                        ti = (kind == 1) ? "R6 irq" : (kind == 3) ? "R9 irq" : "R3 irq";
                        tc = (kind == 1) ? "R6 clr" : (kind == 3) ? "R9 clr" : "R4 clr";
                        step();
                        force_stb = 1'b0;
                        cnt_tick  = 1'b0;
                        chk(tp, wave_out, exp_pin);
                        chk(ti, cmp_irq, m);
                        chk(tc, clr_req, m && (wm == 1));
                        step();
                        chk("R3 irq one cycle", cmp_irq, 1'b0);
                        chk("R4 clr one cycle", clr_req, 1'b0);
                        chk("R9 pin idle hold", wave_out, exp_pin);
                    end
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule